// File: doc/BRIEF.md
# DMA Request Handshake (Device Side)

This block runs the device half of the DMA word handshake on a parallel disk interface. A DMA command is opened with a word count and a direction. While the command is open and the device is selected, the block drives its request line. It raises the request when the local buffer can supply a word (device to host) or take a word (host to device). The host answers with an active-low acknowledge and then moves 16-bit words with its active-low read or write strobe. The block counts each completed strobe and closes the command when the count runs out.

Once raised, the request is held until the host acknowledges. After that it falls or stays up, depending on whether words remain and whether the buffer is still ready. Toward the buffer, read words are taken from a valid/ready source. Written words are pushed out as one-cycle valid pulses. Host behaviour that breaks the handshake raises a one-cycle error pulse.

All host inputs are assumed to be already synchronised to `clk`. Tristate pins are modelled as a value plus an output enable.

Top module: `dma_req_hs`

## Requirements
- R1: After reset, `dreq_oe`, `dd_oe`, `dreq`, `busy`, `tx_ready`, `rx_valid` and `proto_err` are all 0.
- R2: When `cmd_start` is high while idle and `cmd_words` is non-zero, `busy` is 1 after the next edge. The count and the direction (`cmd_to_host`=1 means device to host) are loaded at that edge. `cmd_start` has no effect when `cmd_words` is zero or while a command is open.
- R3: While a command is open, words remain and the buffer is ready, `dreq` is 1 one edge later. Buffer ready means `tx_valid` when the command is device to host, and `rx_ready` when it is host to device. While the buffer is not ready, a request that has not yet been raised stays low.
- R4: Once `dreq` is 1, it stays 1 for as long as `dmack_n` is 1 and the command is open.
- R5: Device-to-host transfers: `dd_oe` is 1 exactly while the command is open, the device is selected, `dmack_n`=0 and `rd_n`=0; during that time `dd_out` equals `tx_data`. In the cycle in which `rd_n` is seen rising with `dmack_n`=0, `tx_ready` is 1 for one cycle and one word is counted.
- R6: Host-to-device transfers: in the cycle in which `wr_n` is seen rising with `dmack_n`=0, `rx_valid` is 1 for one cycle and one word is counted. `rx_data` then holds the `dd_in` value sampled in the last cycle in which `wr_n` was 0.
- R7: The edge that counts the last word closes the command. From then on `busy`, `dreq_oe` and `dreq` are 0.
- R8: `proto_err` pulses one cycle after any of the following, each taken while a command is open and the device is selected:
  - a strobe falls while `dmack_n`=1;
  - `cs0_n` or `cs1_n` is 0;
  - the strobe for the other direction falls.
  A strobe that is not counted leaves the count unchanged.
- R9: While `dev_sel` is 0, `dreq_oe` and `dd_oe` are 0 and strobes are neither counted nor passed to the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Opens a DMA command |
| cmd_to_host | input | 1 | Direction of the command, 1 = device to host |
| cmd_words | input | CW | Number of words in the command |
| dev_sel | input | 1 | This device is the selected one |
| dmack_n | input | 1 | Host DMA acknowledge, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| cs0_n | input | 1 | Host chip select 0, active low |
| cs1_n | input | 1 | Host chip select 1, active low |
| dd_in | input | DW | Data bus as seen by the device |
| dd_out | output | DW | Data bus value driven by the device |
| dd_oe | output | 1 | Data bus drive enable |
| dreq | output | 1 | DMA request value |
| dreq_oe | output | 1 | DMA request drive enable; 0 means high impedance |
| tx_valid | input | 1 | Buffer has a word for the host |
| tx_data | input | DW | Word for the host |
| tx_ready | output | 1 | Word taken from the buffer |
| rx_valid | output | 1 | Word from the host is being handed to the buffer |
| rx_data | output | DW | Word from the host |
| rx_ready | input | 1 | Buffer can take a word |
| proto_err | output | 1 | One-cycle handshake violation pulse |
| busy | output | 1 | A DMA command is open |

## Verification
The completion of the last word can fall in the same cycle as a new `cmd_start`. Because the command is still open on that edge, the new start must be dropped. The bench provokes this by holding `cmd_start` high while it raises the final strobe. It then judges the outcome at the ports: `busy` and `dreq_oe` must both be 0 afterwards, and a fresh start must still work.

// File: rtl/dma_req_hs.sv
module dma_req_hs #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_to_host,
  input  logic [CW-1:0] cmd_words,
  input  logic          dev_sel,
  input  logic          dmack_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          cs0_n,
  input  logic          cs1_n,
  input  logic [DW-1:0] dd_in,
  output logic [DW-1:0] dd_out,
  output logic          dd_oe,
  output logic          dreq,
  output logic          dreq_oe,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  input  logic          rx_ready,
  output logic          proto_err,
  output logic          busy
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic          active, to_host, rd_q, wr_q;
  logic [CW-1:0] left;
  logic [DW-1:0] wr_cap;

  logic en, acked, rd_fall, rd_rise, wr_fall, wr_rise;
  logic done, last, buf_ok, req_nx, err_nx;
  logic [CW-1:0] left_nx;

  assign en      = active & dev_sel;
  assign acked   = ~dmack_n;
  assign rd_fall = ~rd_n & rd_q;
  assign rd_rise = rd_n & ~rd_q;
  assign wr_fall = ~wr_n & wr_q;
  assign wr_rise = wr_n & ~wr_q;

  assign tx_ready = en & to_host & acked & rd_rise;
  assign rx_valid = en & ~to_host & acked & wr_rise;
  assign rx_data  = wr_cap;
  assign dd_out   = tx_data;
  assign dd_oe    = en & to_host & acked & ~rd_n;
  assign dreq_oe  = en;
  assign busy     = active;

  assign done    = tx_ready | rx_valid;
  assign last    = done & (left == ONE);
  assign left_nx = done ? left - ONE : left;
  assign buf_ok  = to_host ? tx_valid : rx_ready;
  assign req_nx  = active & ((dreq & dmack_n) | ((left_nx != '0) & buf_ok & ~last));

  assign err_nx = en & (
      (dmack_n & (rd_fall | wr_fall))
    | ~cs0_n | ~cs1_n
    | (acked & to_host & wr_fall)
    | (acked & ~to_host & rd_fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      to_host   <= 1'b0;
      left      <= '0;
      dreq      <= 1'b0;
      rd_q      <= 1'b1;
      wr_q      <= 1'b1;
      proto_err <= 1'b0;
    end else begin
      rd_q      <= rd_n;
      wr_q      <= wr_n;
      proto_err <= err_nx;
      dreq      <= req_nx;
      if (!active) begin
        if (cmd_start && cmd_words != '0) begin
          active  <= 1'b1;
          to_host <= cmd_to_host;
          left    <= cmd_words;
        end
      end else begin
        left <= left_nx;
        if (last) active <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wr_cap <= '0;
    else if (!wr_n) wr_cap <= dd_in;
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_start && cmd_words != '0) |=> busy);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dreq && dmack_n) |=> dreq);

  assert_bus_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dd_oe |-> (!rd_n && !dmack_n && dev_sel));

  assert_one_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_ready && rx_valid));

  assert_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && left == ONE) |=> (!busy && !dreq_oe));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !dreq);

  assert_cs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dev_sel && (!cs0_n || !cs1_n)) |=> proto_err);

  assert_unsel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_sel |-> (!tx_ready && !rx_valid && !dd_oe));

endmodule

// File: tb/dma_req_hs_bench.sv
module dma_req_hs_bench;
  localparam int DW = 16;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0;
  logic cmd_start = 0, cmd_to_host = 0;
  logic [CW-1:0] cmd_words = '0;
  logic dev_sel = 1, dmack_n = 1, rd_n = 1, wr_n = 1, cs0_n = 1, cs1_n = 1;
  logic [DW-1:0] dd_in = '0;
  logic [DW-1:0] dd_out, rx_data, tx_data;
  logic dd_oe, dreq, dreq_oe, tx_ready, rx_valid, proto_err, busy;
  logic tx_valid = 1, rx_ready = 1;

  int tests = 0, fails = 0, tx_idx = 0, exp_rd = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] word_of(int i);
    return DW'(i * 16'h1357) ^ 16'hA5C3;
  endfunction

  assign tx_data = word_of(tx_idx);
  always @(posedge clk) if (tx_ready) tx_idx <= tx_idx + 1;

  dma_req_hs #(.DW(DW), .CW(CW)) u_dma_req_hs (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_to_host(cmd_to_host),
    .cmd_words(cmd_words), .dev_sel(dev_sel), .dmack_n(dmack_n), .rd_n(rd_n),
    .wr_n(wr_n), .cs0_n(cs0_n), .cs1_n(cs1_n), .dd_in(dd_in), .dd_out(dd_out),
    .dd_oe(dd_oe), .dreq(dreq), .dreq_oe(dreq_oe), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .proto_err(proto_err), .busy(busy));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  // R4 monitor: a raised request never falls while acknowledge is negated
  logic p_dreq = 0, p_dmack_n = 1, p_busy = 0;
  always @(negedge clk) begin
    if (rst_n && p_dreq && p_dmack_n && p_busy && busy && !dreq) begin
      fails++;
      $display("FAIL R4 request dropped before acknowledge actual=0 expected=1");
    end
    p_dreq <= dreq; p_dmack_n <= dmack_n; p_busy <= busy;
  end

  task automatic start(input bit to_host, input int n);
    cmd_to_host = to_host; cmd_words = CW'(n); cmd_start = 1;
    tick();
    cmd_start = 0;
  endtask

  // assumes dmack_n already low
  task automatic host_word(input bit rd, input logic [DW-1:0] w, input string tag);
    if (rd) rd_n = 0; else begin dd_in = w; wr_n = 0; end
    tick();
    if (rd) begin
      chk(dd_oe == 1, {tag, " R5 dd_oe"}, dd_oe, 1);
      chk(dd_out == word_of(exp_rd), {tag, " R5 dd_out"}, dd_out, word_of(exp_rd));
      rd_n = 1;
    end else wr_n = 1;
    #1;
    if (rd) chk(tx_ready == 1, {tag, " R5 tx_ready"}, tx_ready, 1);
    else begin
      chk(rx_valid == 1, {tag, " R6 rx_valid"}, rx_valid, 1);
      chk(rx_data == w, {tag, " R6 rx_data"}, rx_data, w);
    end
    tick();
    if (rd) exp_rd++;
  endtask

  task automatic wait_req();
    while (!dreq) tick();
  endtask

  task automatic rand_run(input int n, input bit rd);
    int got = 0;
    tests++;
    start(rd, n);
    while (got < n) begin
      int stall = $urandom_range(0, 3);
      if (stall != 0 && dmack_n) begin
        if (rd) tx_valid = 0; else rx_ready = 0;
        repeat (stall) tick();
        if (rd) tx_valid = 1; else rx_ready = 1;
      end
      wait_req();
      dmack_n = 0;
      tick();
      host_word(rd, DW'($urandom), "rand");
      got++;
      if ($urandom_range(0, 2) == 0) dmack_n = 1;
    end
    dmack_n = 1;
    tick();
    chk(!busy && !dreq_oe, "R7 random run closed", {busy, dreq_oe}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #5;
    chk(!dreq_oe && !dd_oe && !dreq && !busy && !tx_ready && !rx_valid && !proto_err,
        "R1 reset state", {dreq_oe, dd_oe, dreq, busy}, 0);
    tick(); rst_n = 1; tick();
    chk(!dreq_oe && !busy && !proto_err, "R1 after reset", {dreq_oe, busy, proto_err}, 0);

    start(1, 0);
    chk(busy == 0, "R2 zero count ignored", busy, 0);

    start(1, 3);
    chk(busy && dreq_oe && !dreq, "R2 opened, request not yet up", {busy, dreq_oe, dreq}, 3'b110);
    tick();
    chk(dreq == 1, "R3 request raised", dreq, 1);
    tx_valid = 0;
    repeat (3) tick();
    chk(dreq == 1, "R4 held without acknowledge", dreq, 1);
    tx_valid = 1;
    cmd_words = 9; cmd_start = 1; tick(); cmd_start = 0;
    dmack_n = 0; tick();
    host_word(1, '0, "d1");
    host_word(1, '0, "d2");
    // final word together with a new start
    rd_n = 0; tick();
    cmd_start = 1; cmd_words = 5; rd_n = 1; #1;
    chk(tx_ready == 1, "R5 last word", tx_ready, 1);
    tick(); cmd_start = 0; exp_rd++;
    chk(!busy && !dreq_oe, "R7 closed after 3 words, start while open ignored (R2)", {busy, dreq_oe}, 0);
    dmack_n = 1; tick();
    chk(!dreq, "R7 request gone", dreq, 0);

    rx_ready = 0;
    start(0, 2);
    repeat (3) tick();
    chk(dreq == 0, "R3 withheld while buffer full", dreq, 0);
    rx_ready = 1; tick();
    chk(dreq == 1, "R3 raised when buffer ready", dreq, 1);
    rd_n = 0; tick(); rd_n = 1;
    chk(proto_err == 1, "R8 strobe without acknowledge", proto_err, 1);
    tick();
    chk(proto_err == 0, "R8 pulse one cycle", proto_err, 0);
    cs1_n = 0; tick(); cs1_n = 1;
    chk(proto_err == 1, "R8 chip select during DMA", proto_err, 1);
    dmack_n = 0; tick();
    rd_n = 0; #1;
    chk(dd_oe == 0, "R8 wrong strobe no drive", dd_oe, 0);
    tick(); rd_n = 1; #1;
    chk(proto_err == 1 && tx_ready == 0, "R8 wrong-direction strobe", {proto_err, tx_ready}, 2'b10);
    tick();
    dev_sel = 0; #1;
    chk(!dreq_oe && !dd_oe, "R9 deselected tristate", {dreq_oe, dd_oe}, 0);
    wr_n = 0; tick(); wr_n = 1; #1;
    chk(rx_valid == 0, "R9 strobe ignored while deselected", rx_valid, 0);
    tick(); dev_sel = 1; tick();
    host_word(0, 16'hBEEF, "w1");
    chk(busy == 1, "R8 uncounted strobes left count unchanged", busy, 1);
    host_word(0, 16'h1234, "w2");
    chk(busy == 0, "R7 write closed", busy, 0);
    dmack_n = 1; tick();

    for (int k = 0; k < 24; k++) rand_run($urandom_range(1, 12), 1'($urandom_range(0, 1)));

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule